// File: doc/BRIEF.md
# Single-Shot ADC Conversion Sequencer

This block controls an eight-input analog-to-digital converter for one conversion at a time, started by software. Software uses a simple 32-bit memory-mapped bus. The bus writes the power, soft-reset and enable controls, a one-hot input mask, a sampling period and the interrupt setup. The bus reads back a busy flag, sticky completion flags and one 12-bit result register per input. When software sets the enable bit, the sequencer does four things in order:

1. It waits for the sampling period.
2. It tells the converter front end which input to convert.
3. It waits for the front end's result strobe.
4. It stores the value, raises the input's done flag and drops enable and busy by itself.

The front end handoff is a one-way valid transfer with no back-pressure. The block holds `fe_start` high for one cycle together with `fe_chan` and `fe_sample`. The front end later returns `fe_result`, qualified by a one-cycle `fe_done`. The block has no ready signal: it accepts a `fe_done` in every cycle of the convert phase. A `fe_done` in any other cycle is dropped and has no effect. Bus reads are combinational on `bus_addr`. Bus writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high.

Register offsets are as follows:
- control: 0x00
- mode: 0x04
- input mask: 0x08
- timing: 0x0C
- interrupt setup: 0x20
- flags: 0x24
- divider: 0x28
- result for input n: 0x30 + 4*n

Top module: `adc_seq_ctrl`

## Requirements
- R1: After hardware reset, the registers read as follows: control 0x00000000 (soft reset held, powered down), timing 0x000E0578, divider 0x00000004, flags 0 and every result 0. After reset `irq` is low.
- R2: A control write with bit 0 set starts a conversion only when all of these hold: the block is idle, power bit 2 and soft-reset release bit 15 are already 1 and stay 1 in the write, and the mask has exactly one bit set. The control register then reads 0x8007, with bit 1 as busy. `fe_start` pulses for one cycle S cycles after the write, where S is timing bits 15:0 and S=0 acts as 1. During that pulse `fe_chan` gives the index of the set mask bit and `fe_sample` gives S.
- R3: A `fe_done` during the convert phase stores `fe_result` in that input's result register (bits 11:0) and sets flags bit n. In the next cycle, enable and busy both read 0.
- R4: In pulse mode (interrupt setup bit 31 = 0), `irq` is high for exactly one cycle after a done flag is set if that input's enable (setup bit n) is 1. It stays low if that enable is 0.
- R5: In level mode (setup bit 31 = 1), `irq` is the OR of every set flag whose enable is set. It stays high until those flags are cleared.
- R6: A start attempt with a zero or multi-bit mask does not convert: busy stays 0 and `fe_start` stays low. Instead it sets flags bit 16. If setup bit 16 is 1, it also raises `irq`, as a pulse or a level depending on the mode.
- R7: Writing the flags register clears each flag whose written bit is 1 (bits 7:0 and 16). It leaves the other flags unchanged.
- R8: A control write with bit 0 clear during busy stops the conversion: on the next cycle enable and busy read 0 and no `fe_start` follows. A later stray `fe_done` changes no flag or result.
- R9: A control write that sets the enable bit while busy is ignored: the sample count is not restarted.
- R10: Setting the enable bit does nothing while power bit 2 is 0 or soft-reset release bit 15 is 0: no busy, no `fe_start`.
- R11: A control write that changes bit 15 from 0 to 1 clears every flag and every result register to zero.
- R12: The divider reads 4 at all times, so writes of any other value are ignored. Timing bits 23:16 read 0x0E and bits 31:24 read 0. The mode register keeps only bits 0, 2, 4 and 13:12, so a write of all ones reads back 0x3015.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write when high (with bus_sel) |
| bus_addr | input | 8 | Byte register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| fe_start | output | 1 | One-cycle conversion launch to front end |
| fe_chan | output | 3 | Input index being converted |
| fe_sample | output | 16 | Sampling period of the running conversion |
| fe_done | input | 1 | Result valid strobe from front end |
| fe_result | input | 12 | Conversion result |
| irq | output | 1 | Interrupt, pulse or level |

## Verification
The bench times the gap between a start and `fe_start` for an ordinary period and for a zero period. A design that counted one cycle too few or too many, or stalled on zero, would fail there. It issues a second start while a conversion is running, stops a conversion in mid-sample and then sends a stray result strobe. A design that restarted its count, finished the stopped conversion, or latched data outside the convert phase would show a wrong delay, a spurious `fe_start`, or a flag or result that changed. It sends zero and multi-bit masks, attempts starts while powered down or held in soft reset, and releases soft reset over non-zero flags and results. `irq` is compared against the model on every clock, so an interrupt that is missing, stuck, in the wrong mode or ignores its enable is caught.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SAMPLE,
    SQ_CONVERT
  } seq_state_t;

  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_MODE   = 'h04;
  localparam int OFS_MASK   = 'h08;
  localparam int OFS_TIMING = 'h0C;
  localparam int OFS_IRQCFG = 'h20;
  localparam int OFS_FLAGS  = 'h24;
  localparam int OFS_DIV    = 'h28;
  localparam int OFS_RES    = 'h30;

  localparam logic [31:0] MODE_KEEP = 32'h0000_3015;
  localparam logic [7:0]  CMP_FIXED = 8'h0E;
  localparam int          DIV_ONLY  = 4;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             abort_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             fe_done_i,
  output logic             busy_o,
  output logic             fe_start_o,
  output logic [CH_W-1:0]  fe_chan_o,
  output logic [SMP_W-1:0] fe_smp_o,
  output logic             conv_done_o
);
  seq_state_t       state_q;
  logic [SMP_W-1:0] cnt_q;
  logic [SMP_W-1:0] last_cnt;

  assign last_cnt    = (fe_smp_o == '0) ? '0 : fe_smp_o - SMP_W'(1);
  assign busy_o      = (state_q != SQ_IDLE);
  assign conv_done_o = (state_q == SQ_CONVERT) && fe_done_i && !abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cnt_q      <= '0;
      fe_start_o <= 1'b0;
      fe_chan_o  <= '0;
      fe_smp_o   <= '0;
    end else begin
      fe_start_o <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (launch_i) begin
            state_q   <= SQ_SAMPLE;
            cnt_q     <= '0;
            fe_chan_o <= ch_i;
            fe_smp_o  <= smp_i;
          end
        end
        SQ_SAMPLE: begin
          if (abort_i) begin
            state_q <= SQ_IDLE;
          end else if (cnt_q == last_cnt) begin
            state_q    <= SQ_CONVERT;
            fe_start_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + SMP_W'(1);
          end
        end
        SQ_CONVERT: begin
          if (abort_i || fe_done_i) state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fe_start_o |=> !fe_start_o); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_o |=> !busy_o); // R3
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && busy_o) |=> (!busy_o && !fe_start_o)); // R8
endmodule

// File: rtl/adc_seq_stat.sv
module adc_seq_stat #(
  parameter int NCH   = 8,
  parameter int RES_W = 12,
  parameter int CH_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all_i,
  input  logic                      done_i,
  input  logic [CH_W-1:0]           done_ch_i,
  input  logic [RES_W-1:0]          result_i,
  input  logic                      err_i,
  input  logic                      w1c_i,
  input  logic [NCH-1:0]            w1c_mask_i,
  input  logic                      w1c_err_i,
  input  logic [NCH-1:0]            inten_i,
  input  logic                      err_en_i,
  input  logic                      level_i,
  output logic [NCH-1:0]            stat_o,
  output logic                      err_o,
  output logic [NCH-1:0][RES_W-1:0] res_o,
  output logic                      irq_o
);
  logic pulse_q;
  logic level_irq;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_o[g] <= 1'b0;
        res_o[g]  <= '0;
      end else if (clr_all_i) begin
        stat_o[g] <= 1'b0;
        res_o[g]  <= '0;
      end else if (done_i && (done_ch_i == CH_W'(g))) begin
        stat_o[g] <= 1'b1;
        res_o[g]  <= result_i;
      end else if (w1c_i && w1c_mask_i[g]) begin
        stat_o[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (clr_all_i)               err_o <= 1'b0;
      else if (err_i)              err_o <= 1'b1;
      else if (w1c_i && w1c_err_i) err_o <= 1'b0;
      pulse_q <= (done_i && inten_i[done_ch_i]) || (err_i && err_en_i);
    end
  end

  assign level_irq = (|(stat_o & inten_i)) || (err_o && err_en_i);
  assign irq_o     = level_i ? level_irq : pulse_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (stat_o == '0 && !err_o)); // R11
  AST_ERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !clr_all_i) |=> err_o); // R6
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int RES_W  = 12,
  parameter int SMP_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fe_start,
  output logic [$clog2(NCH)-1:0] fe_chan,
  output logic [SMP_W-1:0]  fe_sample,
  input  logic              fe_done,
  input  logic [RES_W-1:0]  fe_result,
  output logic              irq
);
  localparam int CH_W     = $clog2(NCH);
  localparam int RES_SPAN = 4 * NCH;
  localparam logic [SMP_W-1:0] SMP_RESET = SMP_W'('h578);

  logic              en_q, pwr_q, srst_q;
  logic [DATA_W-1:0] mode_q;
  logic [NCH-1:0]    mask_q, inten_q;
  logic [SMP_W-1:0]  smp_q;
  logic              err_en_q, lvl_q;

  logic wr, wr_ctrl, new_en, new_pwr, new_srst;
  logic busy, start_req, launch, sel_err, abort, conv_done, srst_clr;
  logic mask_ok;
  logic [CH_W-1:0] sel_ch, res_idx;
  logic res_hit;
  logic [NCH-1:0] stat;
  logic err_flag;
  logic [NCH-1:0][RES_W-1:0] res;

  assign wr       = bus_sel && bus_wr;
  assign wr_ctrl  = wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign new_en   = bus_wdata[0];
  assign new_pwr  = bus_wdata[2];
  assign new_srst = bus_wdata[15];

  assign mask_ok   = $onehot(mask_q);
  assign start_req = wr_ctrl && new_en && !busy && pwr_q && srst_q && new_pwr && new_srst;
  assign launch    = start_req && mask_ok;
  assign sel_err   = start_req && !mask_ok;
  assign abort     = wr_ctrl && busy && !(new_en && new_pwr && new_srst);
  assign srst_clr  = wr_ctrl && new_srst && !srst_q;

  always_comb begin
    sel_ch = '0;
    for (int i = 0; i < NCH; i++) if (mask_q[i]) sel_ch = CH_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pwr_q    <= 1'b0;
      srst_q   <= 1'b0;
      mode_q   <= '0;
      mask_q   <= '0;
      smp_q    <= SMP_RESET;
      inten_q  <= '0;
      err_en_q <= 1'b0;
      lvl_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        pwr_q  <= new_pwr;
        srst_q <= new_srst;
      end
      if (launch)                en_q <= 1'b1;
      else if (abort || conv_done) en_q <= 1'b0;
      if (wr && bus_addr == ADDR_W'(OFS_MODE))   mode_q <= bus_wdata & MODE_KEEP;
      if (wr && bus_addr == ADDR_W'(OFS_MASK))   mask_q <= bus_wdata[NCH-1:0];
      if (wr && bus_addr == ADDR_W'(OFS_TIMING)) smp_q  <= bus_wdata[SMP_W-1:0];
      if (wr && bus_addr == ADDR_W'(OFS_IRQCFG)) begin
        inten_q  <= bus_wdata[NCH-1:0];
        err_en_q <= bus_wdata[16];
        lvl_q    <= bus_wdata[31];
      end
    end
  end

  adc_seq_fsm #(.CH_W(CH_W), .SMP_W(SMP_W)) u_fsm (
    .clk, .rst_n,
    .launch_i(launch), .abort_i(abort), .ch_i(sel_ch), .smp_i(smp_q),
    .fe_done_i(fe_done), .busy_o(busy), .fe_start_o(fe_start),
    .fe_chan_o(fe_chan), .fe_smp_o(fe_sample), .conv_done_o(conv_done)
  );

  adc_seq_stat #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_stat (
    .clk, .rst_n,
    .clr_all_i(srst_clr), .done_i(conv_done), .done_ch_i(fe_chan),
    .result_i(fe_result), .err_i(sel_err),
    .w1c_i(wr && bus_addr == ADDR_W'(OFS_FLAGS)),
    .w1c_mask_i(bus_wdata[NCH-1:0]), .w1c_err_i(bus_wdata[16]),
    .inten_i(inten_q), .err_en_i(err_en_q), .level_i(lvl_q),
    .stat_o(stat), .err_o(err_flag), .res_o(res), .irq_o(irq)
  );

  assign res_idx = CH_W'((bus_addr - ADDR_W'(OFS_RES)) >> 2);
  assign res_hit = (bus_addr >= ADDR_W'(OFS_RES)) &&
                   (bus_addr < ADDR_W'(OFS_RES + RES_SPAN));

  always_comb begin
    bus_rdata = '0;
    if (res_hit) begin
      bus_rdata[RES_W-1:0] = res[res_idx];
    end else begin
      case (int'(bus_addr))
        OFS_CTRL: begin
          bus_rdata[0]  = en_q;
          bus_rdata[1]  = busy;
          bus_rdata[2]  = pwr_q;
          bus_rdata[15] = srst_q;
        end
        OFS_MODE:   bus_rdata = mode_q;
        OFS_MASK:   bus_rdata[NCH-1:0] = mask_q;
        OFS_TIMING: begin
          bus_rdata[SMP_W-1:0] = smp_q;
          bus_rdata[23:16]     = CMP_FIXED;
        end
        OFS_IRQCFG: begin
          bus_rdata[NCH-1:0] = inten_q;
          bus_rdata[16]      = err_en_q;
          bus_rdata[31]      = lvl_q;
        end
        OFS_FLAGS: begin
          bus_rdata[NCH-1:0] = stat;
          bus_rdata[16]      = err_flag;
        end
        OFS_DIV:    bus_rdata = DATA_W'(DIV_ONLY);
        default:    bus_rdata = '0;
      endcase
    end
  end

  AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    fe_start |-> (pwr_q && srst_q)); // R10
  AST_BUSY_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en_q); // R8
  AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !busy); // R6
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        fe_start, fe_done = 0, irq;
  logic [2:0]  fe_chan;
  logic [15:0] fe_sample;
  logic [11:0] fe_result = 0;

  int n_chk = 0, n_err = 0;
  bit mon_on = 0, exp_irq = 0, finished = 0;
  int exp_stat = 0;
  int exp_res[8];

  always #5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .fe_start, .fe_chan, .fe_sample, .fe_done, .fe_result, .irq
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Interrupt line against the model, every cycle (R4, R5, R6)
  always @(negedge clk) if (mon_on) begin
    #2;
    chk("R4/R5 irq per-cycle", {31'b0, irq}, {31'b0, exp_irq});
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic chkrd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic no_start(input string tag, input int cycles);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      if (fe_start) seen = 1;
      @(negedge clk);
    end
    chk(tag, {31'b0, seen}, 32'd0);
  endtask

  task automatic conv(input int ch, input int s, input int l, input int val, input bit ie);
    int k = 0;
    wr(8'h00, 32'h8005);
    chkrd("R2 busy after start", 8'h00, 32'h8007);
    while (!fe_start && k < 100) begin @(negedge clk); k++; end
    chk("R2 start delay", k, (s == 0) ? 1 : s);
    chk("R2 channel", {29'b0, fe_chan}, ch);
    chk("R2 sample count", {16'b0, fe_sample}, s);
    @(negedge clk);
    chk("R2 start single cycle", {31'b0, fe_start}, 0);
    repeat (l) @(negedge clk);
    fe_result = val[11:0]; fe_done = 1;
    @(negedge clk);
    fe_done = 0; exp_irq = ie;
    exp_stat = exp_stat | (1 << ch); exp_res[ch] = val;
    chkrd("R3 enable and busy clear", 8'h00, 32'h8004);
    chkrd("R3 flags", 8'h24, exp_stat);
    chkrd("R3 result stored", 8'h30 + 8'(4 * ch), exp_res[ch]);
    @(negedge clk);
    exp_irq = 0;
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    foreach (exp_res[i]) exp_res[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;
    // R1 reset state
    chkrd("R1 control reset", 8'h00, 32'h0);
    chkrd("R1 timing reset", 8'h0C, 32'h000E0578);
    chkrd("R1 divider reset", 8'h28, 32'h4);
    chkrd("R1 flags reset", 8'h24, 32'h0);
    chkrd("R1 result reset", 8'h3C, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 0);

    // R2 R3 R4: enabled pulse interrupt
    wr(8'h00, 32'h8004);
    wr(8'h08, 32'h08);
    wr(8'h20, 32'h08);
    wr(8'h0C, 32'd5);
    conv(3, 5, 3, 'hABC, 1);

    // R4 disabled input, R2 zero sample period
    wr(8'h08, 32'h01);
    wr(8'h0C, 32'd0);
    conv(0, 0, 0, 'h123, 0);

    // R7 write-one-to-clear
    wr(8'h24, 32'h08);
    exp_stat = 1;
    chkrd("R7 selective clear", 8'h24, exp_stat);

    // R5 level mode
    wr(8'h20, 32'h80000001);
    exp_irq = 1;
    chk("R5 level irq high", {31'b0, irq}, 1);
    @(negedge clk);
    wr(8'h24, 32'h01);
    exp_irq = 0; exp_stat = 0;
    chkrd("R5 flags cleared", 8'h24, 0);
    wr(8'h20, 32'h00010004);

    // R6 select errors
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h8005);
    exp_irq = 1; exp_stat = 'h10000;
    chkrd("R6 zero mask no busy", 8'h00, 32'h8004);
    chkrd("R6 error flag", 8'h24, exp_stat);
    @(negedge clk);
    exp_irq = 0;
    no_start("R6 no launch zero mask", 10);
    wr(8'h08, 32'h05);
    wr(8'h00, 32'h8005);
    exp_irq = 1;
    chkrd("R6 multi mask no busy", 8'h00, 32'h8004);
    @(negedge clk);
    exp_irq = 0;
    no_start("R6 no launch multi mask", 10);
    wr(8'h24, 32'h10000);
    exp_stat = 0;
    chkrd("R7 error flag cleared", 8'h24, 0);

    // R8 stop in mid-sample, then a stray strobe
    wr(8'h08, 32'h04);
    wr(8'h0C, 32'd20);
    wr(8'h00, 32'h8005);
    repeat (3) @(negedge clk);
    wr(8'h00, 32'h8004);
    chkrd("R8 stop clears busy", 8'h00, 32'h8004);
    no_start("R8 no launch after stop", 25);
    fe_result = 'h777; fe_done = 1;
    @(negedge clk);
    fe_done = 0;
    @(negedge clk);
    chkrd("R8 stray strobe flags", 8'h24, exp_stat);
    chkrd("R8 stray strobe result", 8'h38, exp_res[2]);

    // R9 repeated start while busy
    begin
      int k;
      wr(8'h0C, 32'd6);
      wr(8'h00, 32'h8005);
      @(negedge clk);
      wr(8'h00, 32'h8005);
      k = 2;
      while (!fe_start && k < 100) begin @(negedge clk); k++; end
      chk("R9 count not restarted", k, 6);
      fe_result = 'h456; fe_done = 1;
      @(negedge clk);
      fe_done = 0; exp_irq = 1;
      exp_stat = 'h4; exp_res[2] = 'h456;
      chkrd("R9 flags", 8'h24, exp_stat);
      chkrd("R9 result", 8'h38, exp_res[2]);
      @(negedge clk);
      exp_irq = 0;
    end

    // R10 power-down and soft reset block starts
    wr(8'h00, 32'h8001);
    chkrd("R10 powered down ignores enable", 8'h00, 32'h8000);
    no_start("R10 no launch powered down", 10);
    wr(8'h00, 32'h0004);
    wr(8'h00, 32'h0005);
    chkrd("R10 soft reset ignores enable", 8'h00, 32'h0004);
    no_start("R10 no launch in soft reset", 10);

    // R11 soft-reset release clears flags and results
    wr(8'h00, 32'h8004);
    exp_stat = 0;
    foreach (exp_res[i]) exp_res[i] = 0;
    chkrd("R11 flags cleared", 8'h24, 0);
    chkrd("R11 result2 cleared", 8'h38, 0);
    chkrd("R11 result3 cleared", 8'h3C, 0);
    chkrd("R11 result0 cleared", 8'h30, 0);

    // R12 fixed fields
    wr(8'h28, 32'd5);
    chkrd("R12 divider fixed", 8'h28, 32'h4);
    wr(8'h0C, 32'hFFFF1234);
    chkrd("R12 timing fixed fields", 8'h0C, 32'h000E1234);
    wr(8'h04, 32'hFFFFFFFF);
    chkrd("R12 mode kept bits", 8'h04, 32'h3015);

    @(negedge clk);
    mon_on = 0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule